// File: doc/BRIEF.md
# Transaction Conflict Profiling Monitor

This block sits beside one transactional data cache and watches its transactions without feeding anything back into them. It counts the cycles that have passed since the current transaction began. For every line read inside that transaction, it remembers the program counter of the load that first touched the line. When a dependency violation aborts the transaction, the monitor builds one record. The record holds the conflicting address, the ID of the thread whose commit caused the violation, the captured read PC and the cycles the aborted work had consumed.

Records queue in a small FIFO that software drains at its own pace through a pop strobe. When the queue is full and nothing is popped, new records are lost and a sticky flag reports the loss. The monitor has no path into the cache or the commit logic. It therefore cannot change how transactions interleave.

Top module: `txn_conflict_monitor`

## Requirements
- R1: After reset the FIFO is empty (rec_valid_o low) and rec_overflow_o is low.
- R2: An abort N cycles after the cycle in which tx_begin_i was high records rec_cycles_o = N. The begin cycle is cycle 0, and every cycle in between counts.
- R3: The cycle count saturates at 2^CYC_W-1 and does not wrap.
- R4: A record carries abort_addr_i and abort_tid_i exactly as they were presented in the abort cycle.
- R5: The record's read PC is the rd_pc_i of the first read of abort_line_i in the current transaction, with rec_pc_valid_o high. Later reads of the same line do not replace it.
- R6: If abort_line_i was not read in the current transaction, the record has rec_pc_valid_o low and rec_pc_o zero.
- R7: A new tx_begin_i forgets every read PC captured in earlier transactions and restarts the count.
- R8: An abort produces a record only while a transaction is open. A transaction closes on abort or on tx_commit_i, and opens on tx_begin_i.
- R9: Records leave the FIFO in arrival order. The head record stays on the outputs until rec_pop_i is high in a cycle.
- R10: An abort that arrives while the FIFO holds FIFO_DEPTH records and nothing is popped is dropped, and rec_overflow_o goes high. The flag stays high while the FIFO is drained. Records already stored are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_begin_i | input | 1 | Transaction start strobe |
| tx_commit_i | input | 1 | Transaction committed normally |
| rd_valid_i | input | 1 | Transactional load this cycle |
| rd_line_i | input | LINE_W | Cache line index of the load |
| rd_pc_i | input | PC_W | PC of the load |
| abort_i | input | 1 | Conflict abort strobe |
| abort_line_i | input | LINE_W | Line index of the conflicting line |
| abort_addr_i | input | ADDR_W | Conflicting address |
| abort_tid_i | input | TID_W | ID of the committing thread |
| rec_pop_i | input | 1 | Remove the head record |
| rec_valid_o | output | 1 | A record is at the head |
| rec_addr_o | output | ADDR_W | Head record: address |
| rec_tid_o | output | TID_W | Head record: writer thread |
| rec_pc_valid_o | output | 1 | Head record: read PC captured |
| rec_pc_o | output | PC_W | Head record: read PC |
| rec_cycles_o | output | CYC_W | Head record: wasted cycles |
| rec_overflow_o | output | 1 | Sticky record-loss flag |

## Verification
The bench starts transactions and aborts them after known gaps: one cycle, a few cycles with reads in between, and far past the counter limit. This separates off-by-one counting from saturation. Read patterns include repeated reads of the victim line, reads of other lines only, and no reads after a fresh begin. These tell first-read capture apart from last-read capture and expose stale entries. Aborts outside any transaction, and bursts of aborts against a full queue, separate gating and overflow behaviour from normal record order.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  localparam int unsigned DEF_ADDR_W = 32;
  localparam int unsigned DEF_TID_W  = 4;
  localparam int unsigned DEF_PC_W   = 32;
  localparam int unsigned DEF_CYC_W  = 16;
  localparam int unsigned DEF_LINE_W = 6;
  localparam int unsigned DEF_DEPTH  = 4;

  typedef enum logic {TXN_IDLE = 1'b0, TXN_OPEN = 1'b1} txn_state_e;
endpackage

// File: rtl/tcm_cycle_ctr.sv
module tcm_cycle_ctr
  import tcm_pkg::*;
#(
  parameter int unsigned CYC_W = DEF_CYC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             begin_i,
  input  logic             end_i,
  output logic             open_o,
  output logic [CYC_W-1:0] cnt_o
);
  localparam logic [CYC_W-1:0] CNT_MAX = {CYC_W{1'b1}};

  txn_state_e       st_q, st_d;
  logic [CYC_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    st_d = st_q;
    if (begin_i)    st_d = TXN_OPEN;
    else if (end_i) st_d = TXN_IDLE;
  end

  always_comb begin
    cnt_en = begin_i || (st_q == TXN_OPEN && cnt_q != CNT_MAX);
    if (begin_i) cnt_d = {{(CYC_W-1){1'b0}}, 1'b1};
    else         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TXN_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign open_o = (st_q == TXN_OPEN);
  assign cnt_o  = cnt_q;

  // R3
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (open_o && !begin_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (open_o && !begin_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R7
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    begin_i |=> (cnt_q == 1 && open_o));
endmodule

// File: rtl/tcm_read_pc_table.sv
module tcm_read_pc_table
  import tcm_pkg::*;
#(
  parameter int unsigned LINE_W = DEF_LINE_W,
  parameter int unsigned PC_W   = DEF_PC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              cap_i,
  input  logic [LINE_W-1:0] cap_line_i,
  input  logic [PC_W-1:0]   cap_pc_i,
  input  logic [LINE_W-1:0] look_line_i,
  output logic              look_vld_o,
  output logic [PC_W-1:0]   look_pc_o
);
  localparam int unsigned LINES = 1 << LINE_W;

  logic [LINES-1:0] vld_q;
  logic [PC_W-1:0]  pc_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic hit, vld_d, vld_en, pc_en;

    always_comb begin
      hit    = cap_i && (cap_line_i == LINE_W'(g)) && !vld_q[g];
      vld_en = clear_i || hit;
      vld_d  = !clear_i;
      pc_en  = hit && !clear_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
        pc_q[g]  <= '0;
      end else begin
        if (vld_en) vld_q[g] <= vld_d;
        if (pc_en)  pc_q[g]  <= cap_pc_i;
      end
    end
  end

  assign look_vld_o = vld_q[look_line_i];
  assign look_pc_o  = vld_q[look_line_i] ? pc_q[look_line_i] : '0;

  // R7
  tbl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> vld_q == '0);

  // R5
  tbl_keep_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && look_vld_o) |=> (look_line_i != $past(look_line_i)) || look_pc_o == $past(look_pc_o));
endmodule

// File: rtl/tcm_record_fifo.sv
module tcm_record_fifo
  import tcm_pkg::*;
#(
  parameter int unsigned WIDTH = 85,
  parameter int unsigned DEPTH = DEF_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] head_o,
  output logic             overflow_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             full, empty, do_push, do_pop;

  always_comb begin
    full    = (cnt_q == CNT_FULL);
    empty   = (cnt_q == '0);
    do_pop  = pop_i && !empty;
    do_push = push_i && (!full || do_pop);
    wr_d    = (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
    rd_d    = (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
    cnt_d   = cnt_q;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    ovf_d   = ovf_q || (push_i && !do_push);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (do_push) wr_q <= wr_d;
      if (do_pop)  rd_q <= rd_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = do_push && (wr_q == PTR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem_q[g] <= '0;
      else if (slot_en) mem_q[g] <= push_data_i;
    end
  end

  assign valid_o    = !empty;
  assign head_o     = mem_q[rd_q];
  assign overflow_o = ovf_q;

  // R10
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

  // R9
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !pop_i) |=> (valid_o && $stable(head_o)));
endmodule

// File: rtl/txn_conflict_monitor.sv
module txn_conflict_monitor
  import tcm_pkg::*;
#(
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned TID_W      = DEF_TID_W,
  parameter int unsigned PC_W       = DEF_PC_W,
  parameter int unsigned CYC_W      = DEF_CYC_W,
  parameter int unsigned LINE_W     = DEF_LINE_W,
  parameter int unsigned FIFO_DEPTH = DEF_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_begin_i,
  input  logic              tx_commit_i,
  input  logic              rd_valid_i,
  input  logic [LINE_W-1:0] rd_line_i,
  input  logic [PC_W-1:0]   rd_pc_i,
  input  logic              abort_i,
  input  logic [LINE_W-1:0] abort_line_i,
  input  logic [ADDR_W-1:0] abort_addr_i,
  input  logic [TID_W-1:0]  abort_tid_i,
  input  logic              rec_pop_i,
  output logic              rec_valid_o,
  output logic [ADDR_W-1:0] rec_addr_o,
  output logic [TID_W-1:0]  rec_tid_o,
  output logic              rec_pc_valid_o,
  output logic [PC_W-1:0]   rec_pc_o,
  output logic [CYC_W-1:0]  rec_cycles_o,
  output logic              rec_overflow_o
);
  localparam int unsigned REC_W = ADDR_W + TID_W + 1 + PC_W + CYC_W;

  logic             txn_open;
  logic [CYC_W-1:0] cyc_cnt;
  logic             cap_en, push;
  logic             look_vld;
  logic [PC_W-1:0]  look_pc;
  logic [REC_W-1:0] rec_in, rec_head;

  tcm_cycle_ctr #(.CYC_W(CYC_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .begin_i (tx_begin_i),
    .end_i   (abort_i || tx_commit_i),
    .open_o  (txn_open),
    .cnt_o   (cyc_cnt)
  );

  assign cap_en = rd_valid_i && txn_open && !tx_begin_i;

  tcm_read_pc_table #(.LINE_W(LINE_W), .PC_W(PC_W)) u_tbl (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (tx_begin_i),
    .cap_i       (cap_en),
    .cap_line_i  (rd_line_i),
    .cap_pc_i    (rd_pc_i),
    .look_line_i (abort_line_i),
    .look_vld_o  (look_vld),
    .look_pc_o   (look_pc)
  );

  assign push   = abort_i && txn_open;
  assign rec_in = {abort_addr_i, abort_tid_i, look_vld, look_pc, cyc_cnt};

  tcm_record_fifo #(.WIDTH(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push),
    .push_data_i (rec_in),
    .pop_i       (rec_pop_i),
    .valid_o     (rec_valid_o),
    .head_o      (rec_head),
    .overflow_o  (rec_overflow_o)
  );

  assign {rec_addr_o, rec_tid_o, rec_pc_valid_o, rec_pc_o, rec_cycles_o} = rec_head;

  // R8
  idle_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && !txn_open && !rec_valid_o) |=> !rec_valid_o);

  // R9
  push_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> rec_valid_o || rec_overflow_o);

  // R6
  unread_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_pc_valid_o |-> rec_pc_o == '0);
endmodule

// File: tb/txn_conflict_monitor_tb.sv
module txn_conflict_monitor_tb;
  localparam int ADDR_W = 32, TID_W = 4, PC_W = 32, CYC_W = 8, LINE_W = 6, DEPTH = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              tx_begin_i, tx_commit_i, rd_valid_i, abort_i, rec_pop_i;
  logic [LINE_W-1:0] rd_line_i, abort_line_i;
  logic [PC_W-1:0]   rd_pc_i;
  logic [ADDR_W-1:0] abort_addr_i;
  logic [TID_W-1:0]  abort_tid_i;
  logic              rec_valid_o, rec_pc_valid_o, rec_overflow_o;
  logic [ADDR_W-1:0] rec_addr_o;
  logic [TID_W-1:0]  rec_tid_o;
  logic [PC_W-1:0]   rec_pc_o;
  logic [CYC_W-1:0]  rec_cycles_o;

  int checks = 0, errors = 0, elapsed = 0;

  always #2 clk = ~clk;

  txn_conflict_monitor #(.ADDR_W(ADDR_W), .TID_W(TID_W), .PC_W(PC_W), .CYC_W(CYC_W),
                         .LINE_W(LINE_W), .FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_begin_i(tx_begin_i), .tx_commit_i(tx_commit_i),
    .rd_valid_i(rd_valid_i), .rd_line_i(rd_line_i), .rd_pc_i(rd_pc_i),
    .abort_i(abort_i), .abort_line_i(abort_line_i), .abort_addr_i(abort_addr_i),
    .abort_tid_i(abort_tid_i), .rec_pop_i(rec_pop_i), .rec_valid_o(rec_valid_o),
    .rec_addr_o(rec_addr_o), .rec_tid_o(rec_tid_o), .rec_pc_valid_o(rec_pc_valid_o),
    .rec_pc_o(rec_pc_o), .rec_cycles_o(rec_cycles_o), .rec_overflow_o(rec_overflow_o));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FIFO_MON FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    tx_begin_i = 0; tx_commit_i = 0; rd_valid_i = 0; abort_i = 0; rec_pop_i = 0;
    rd_line_i = '0; rd_pc_i = '0; abort_line_i = '0; abort_addr_i = '0; abort_tid_i = '0;
  endtask

  // Each one-cycle task starts and ends at a falling edge.
  task automatic cyc_idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); elapsed++;
    end
  endtask

  task automatic cyc_begin();
    tx_begin_i = 1; @(negedge clk); tx_begin_i = 0; elapsed = 0;
  endtask

  task automatic cyc_commit();
    tx_commit_i = 1; @(negedge clk); tx_commit_i = 0; elapsed++;
  endtask

  task automatic cyc_read(input logic [LINE_W-1:0] line, input logic [PC_W-1:0] pc);
    rd_valid_i = 1; rd_line_i = line; rd_pc_i = pc;
    @(negedge clk); rd_valid_i = 0; elapsed++;
  endtask

  // Returns the wasted-cycle value the requirements predict (R2, R3).
  task automatic cyc_abort(input logic [LINE_W-1:0] line, input logic [ADDR_W-1:0] addr,
                           input logic [TID_W-1:0] tid, output int exp_cyc);
    int n;
    n = elapsed + 1;
    exp_cyc = (n > 255) ? 255 : n;
    abort_i = 1; abort_line_i = line; abort_addr_i = addr; abort_tid_i = tid;
    @(negedge clk); abort_i = 0; elapsed++;
  endtask

  task automatic cyc_pop();
    rec_pop_i = 1; @(negedge clk); rec_pop_i = 0;
  endtask

  task automatic t_reset();
    check("R1 valid after reset", rec_valid_o, 0);
    check("R1 overflow after reset", rec_overflow_o, 0);
  endtask

  task automatic t_basic();
    int e;
    cyc_begin();
    cyc_read(6'd5, 32'hA000_0010);
    cyc_idle(3);
    cyc_read(6'd5, 32'hB000_0020);
    cyc_read(6'd7, 32'hC000_0030);
    cyc_idle(2);
    cyc_abort(6'd5, 32'hDEAD_BEE0, 4'd3, e);
    check("R9 record present", rec_valid_o, 1);
    check("R4 address", rec_addr_o, 32'hDEAD_BEE0);
    check("R4 thread id", rec_tid_o, 3);
    check("R5 first read pc", rec_pc_o, 32'hA000_0010);
    check("R5 pc valid", rec_pc_valid_o, 1);
    check("R2 wasted cycles", rec_cycles_o, e);
    cyc_idle(2);
    check("R9 head held", rec_addr_o, 32'hDEAD_BEE0);
    cyc_pop();
    check("R9 empty after pop", rec_valid_o, 0);
  endtask

  task automatic t_unread();
    int e;
    cyc_begin();
    cyc_read(6'd2, 32'h1111_2222);
    cyc_abort(6'd9, 32'h0000_4440, 4'd1, e);
    check("R6 pc valid low", rec_pc_valid_o, 0);
    check("R6 pc zero", rec_pc_o, 0);
    check("R2 cycles two", rec_cycles_o, 2);
    cyc_pop();
  endtask

  task automatic t_new_txn();
    int e;
    cyc_begin();
    cyc_read(6'd4, 32'h0D0D_0D0D);
    cyc_abort(6'd4, 32'h0000_0400, 4'd2, e);
    check("R5 pc before restart", rec_pc_o, 32'h0D0D_0D0D);
    cyc_pop();
    cyc_begin();
    cyc_abort(6'd4, 32'h0000_0404, 4'd2, e);
    check("R7 stale pc cleared", rec_pc_valid_o, 0);
    check("R7 count restarted", rec_cycles_o, 1);
    cyc_pop();
  endtask

  task automatic t_idle_abort();
    int e;
    cyc_abort(6'd1, 32'h0000_0100, 4'd5, e);
    check("R8 abort after abort", rec_valid_o, 0);
    cyc_begin();
    cyc_commit();
    cyc_abort(6'd1, 32'h0000_0100, 4'd5, e);
    check("R8 abort after commit", rec_valid_o, 0);
  endtask

  task automatic t_saturate();
    int e;
    cyc_begin();
    cyc_idle(300);
    cyc_abort(6'd0, 32'h0000_0900, 4'd6, e);
    check("R3 saturated cycles", rec_cycles_o, e);
    check("R3 max value", rec_cycles_o, 255);
    cyc_pop();
  endtask

  task automatic t_overflow();
    int e;
    for (int k = 0; k < DEPTH + 1; k++) begin
      cyc_begin();
      cyc_abort(6'd3, 32'h5000_0000 + k, TID_W'(k), e);
    end
    check("R10 overflow flag", rec_overflow_o, 1);
    for (int k = 0; k < DEPTH; k++) begin
      check("R9 order tid", rec_tid_o, k);
      check("R10 stored address", rec_addr_o, 32'h5000_0000 + k);
      cyc_pop();
    end
    check("R10 extra dropped", rec_valid_o, 0);
    check("R10 flag stays", rec_overflow_o, 1);
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_unread();
    t_new_txn();
    t_idle_abort();
    t_saturate();
    t_overflow();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("WATCHDOG FAIL all: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule